// File: doc/BRIEF.md
# Vector Word Carry and Borrow Unit

This block is one integer execution slice of a 128-bit vector datapath. Each cycle it may accept an instruction word and two 128-bit source values that were already read from the register file. It decodes the word and works on four independent 32-bit unsigned lanes. It can produce the carry flag of a lane-wise add, the wrapped lane-wise sum, or a flag per lane that is set when a lane-wise subtract needs no borrow. Software pairs the carry result with the wrapped sum and moves the carry vector one word to the left between steps. Repeating this builds additions wider than 32 bits, up to a full 128-bit add.

The result, the destination register index and a write strobe appear one clock after the instruction is issued. A word that does not decode to one of the three operations raises an illegal-instruction flag and blocks the write. No status, carry or condition state is kept or updated.

Top module: `vwc_unit`

## Requirements
- R1: Bit 0 of the instruction word is bit 31 of `instr_i`. The primary opcode is `instr_i[31:26]` and must equal 4. The destination index is `instr_i[25:21]`, the extended opcode is `instr_i[10:0]`, and `instr_i[20:11]` name the sources and do not affect the result. On a legal issue, `wr_idx_o` carries the destination field.
- R2: With extended opcode 384, each result lane is 1 when the unsigned 33-bit sum of the two source lanes is 2^32 or more, and 0 otherwise. The sum is not returned.
- R3: With extended opcode 128, each result lane is (A+B) mod 2^32. There is no saturation.
- R4: With extended opcode 1408, each result lane is 1 when A >= B unsigned (equal values give 1), and 0 otherwise.
- R5: For opcodes 384 and 1408, bits 31:1 of every result lane are zero.
- R6: Lane 0 is bits 127:96 and lane 3 is bits 31:0. Lanes do not interact, and no carry passes from one lane to the next.
- R7: An issued word with a primary opcode other than 4, or with any other extended opcode, sets `illegal_o` for one cycle. It keeps `wr_en_o` low and leaves `result_o` unchanged.
- R8: When `issue_i` is low, the next cycle has `wr_en_o` and `illegal_o` low and `result_o` unchanged.
- R9: While reset is asserted, all outputs are zero.
- R10: Outputs for an issue appear exactly one clock edge later, and `wr_en_o` and `illegal_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 128 | Value of source register A |
| src_b_i | input | 128 | Value of source register B |
| result_o | output | 128 | Lane-wise result |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Issued word was not a legal operation |

## Verification
The assertions check several properties on every cycle. Write and illegal are mutually exclusive, and each follows an issue by one cycle. The result holds while nothing is written. Carry and no-borrow lanes are flags of one bit. The sum and the no-borrow flag of a sample lane match the sources from the cycle before.

Other behaviours can only be shown by the bench's scenarios. These include exact carry values at the 2^32 boundary and equal values for the borrow flag. They also include the big-endian lane placement, the two kinds of illegal word, and register-field decoding. The bench also chains carry and wrapped-sum steps with a one-word shift into a full 128-bit add, including the all-ones plus one ripple through every lane.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  typedef enum logic [1:0] {
    VOP_NONE     = 2'd0,
    VOP_CARRY    = 2'd1,
    VOP_WRAPSUM  = 2'd2,
    VOP_NOBORROW = 2'd3
  } vop_e;

  localparam int PRI_W     = 6;
  localparam int XO_W      = 11;
  localparam int IDX_W     = 5;
  localparam int INSTR_W   = 32;
  localparam logic [PRI_W-1:0] PRI_VECTOR  = 6'd4;
  localparam logic [XO_W-1:0]  XO_CARRY    = 11'd384;
  localparam logic [XO_W-1:0]  XO_WRAPSUM  = 11'd128;
  localparam logic [XO_W-1:0]  XO_NOBORROW = 11'd1408;
endpackage

// File: rtl/vwc_decode.sv
module vwc_decode
  import vwc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output vop_e               op,
  output logic               legal,
  output logic [IDX_W-1:0]   dest
);
  localparam int PRI_LSB  = INSTR_W - PRI_W;
  localparam int DEST_LSB = PRI_LSB - IDX_W;

  logic [PRI_W-1:0] pri_f;
  logic [XO_W-1:0]  xo_f;

  assign pri_f = instr[INSTR_W-1:PRI_LSB];
  assign dest  = instr[PRI_LSB-1:DEST_LSB];
  assign xo_f  = instr[XO_W-1:0];

  always_comb begin
    op = VOP_NONE;
    if (pri_f == PRI_VECTOR) begin
      unique case (xo_f)
        XO_CARRY:    op = VOP_CARRY;
        XO_WRAPSUM:  op = VOP_WRAPSUM;
        XO_NOBORROW: op = VOP_NOBORROW;
        default:     op = VOP_NONE;
      endcase
    end
  end

  assign legal = (op != VOP_NONE);
endmodule

// File: rtl/vwc_lane.sv
module vwc_lane
  import vwc_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  vop_e              op,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] res
);
  function automatic logic [LANE_W:0] wide_add(input logic [LANE_W-1:0] x, input logic [LANE_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [LANE_W-1:0] as_flag(input logic f);
    return {{(LANE_W-1){1'b0}}, f};
  endfunction

  logic [LANE_W:0] sum_w;
  logic            carry_out;
  logic            no_borrow;

  assign sum_w     = wide_add(a, b);
  assign carry_out = sum_w[LANE_W];
  assign no_borrow = (a >= b);

  always_comb begin
    unique case (op)
      VOP_CARRY:    res = as_flag(carry_out);
      VOP_WRAPSUM:  res = sum_w[LANE_W-1:0];
      VOP_NOBORROW: res = as_flag(no_borrow);
      default:      res = '0;
    endcase
  end
endmodule

// File: rtl/vwc_unit.sv
module vwc_unit
  import vwc_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic [31:0]        instr_i,
  input  logic [VEC_W-1:0]   src_a_i,
  input  logic [VEC_W-1:0]   src_b_i,
  output logic [VEC_W-1:0]   result_o,
  output logic               wr_en_o,
  output logic [4:0]         wr_idx_o,
  output logic               illegal_o
);
  vop_e             dec_op;
  logic             dec_legal;
  logic [IDX_W-1:0] dec_dest;
  logic [VEC_W-1:0] lane_res;
  logic             src_fields_unused;
  logic             do_write;
  logic             do_trap;

  assign src_fields_unused = ^instr_i[20:11];

  vwc_decode u_dec (
    .instr (instr_i),
    .op    (dec_op),
    .legal (dec_legal),
    .dest  (dec_dest)
  );

  // lane 0 is the most-significant word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = VEC_W - 1 - g * LANE_W;
    vwc_lane #(.LANE_W(LANE_W)) u_lane (
      .op  (dec_op),
      .a   (src_a_i[HI -: LANE_W]),
      .b   (src_b_i[HI -: LANE_W]),
      .res (lane_res[HI -: LANE_W])
    );
  end

  assign do_write = issue_i && dec_legal;
  assign do_trap  = issue_i && !dec_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      wr_en_o   <= do_write;
      illegal_o <= do_trap;
      if (do_write) begin
        result_o <= lane_res;
        wr_idx_o <= dec_dest;
      end
    end
  end
endmodule

// File: rtl/vwc_checker.sv
module vwc_checker #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [31:0]      instr_i,
  input logic [VEC_W-1:0] src_a_i,
  input logic [VEC_W-1:0] src_b_i,
  input logic [VEC_W-1:0] result_o,
  input logic             wr_en_o,
  input logic             illegal_o
);
  logic flag_op_in;
  logic sum_op_in;
  logic nb_op_in;
  logic [LANES-1:0] upper_zero;

  assign flag_op_in = (instr_i[10:0] == 11'd384) || (instr_i[10:0] == 11'd1408);
  assign sum_op_in  = (instr_i[10:0] == 11'd128);
  assign nb_op_in   = (instr_i[10:0] == 11'd1408);

  for (genvar g = 0; g < LANES; g++) begin : g_uz
    assign upper_zero[g] = (result_o[g*LANE_W + 1 +: LANE_W-1] == '0);
  end

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && illegal_o));

  assert_write_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (wr_en_o || illegal_o));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!wr_en_o && !illegal_o));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_o |-> $stable(result_o));

  assert_flag_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && flag_op_in) |=> (!wr_en_o || (&upper_zero)));

  assert_wrap_lane3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && sum_op_in) |=> (!wr_en_o ||
      result_o[LANE_W-1:0] == $past(src_a_i[LANE_W-1:0] + src_b_i[LANE_W-1:0])));

  assert_noborrow_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && nb_op_in) |=> (!wr_en_o ||
      result_o[VEC_W-LANE_W] == $past(src_a_i[VEC_W-1 -: LANE_W] >= src_b_i[VEC_W-1 -: LANE_W])));
endmodule

bind vwc_unit vwc_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_i   (issue_i),
  .instr_i   (instr_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_vwc_unit.sv
module tb_vwc_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic [127:0] result_o;
  logic         wr_en_o;
  logic [4:0]   wr_idx_o;
  logic         illegal_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vwc_unit dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .illegal_o(illegal_o)
  );

  localparam logic [10:0] K_CARRY = 11'd384;
  localparam logic [10:0] K_SUM   = 11'd128;
  localparam logic [10:0] K_NB    = 11'd1408;

  function automatic logic [31:0] word(input logic [5:0] pri, input logic [4:0] d,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [10:0] xo);
    return {pri, d, a, b, xo};
  endfunction

  function automatic logic [31:0] lane(input logic [127:0] v, input int i);
    return v[127 - 32*i -: 32];
  endfunction

  function automatic logic [127:0] ref_carry(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      logic [32:0] s = {1'b0, lane(a, i)} + {1'b0, lane(b, i)};
      r[127 - 32*i -: 32] = s > 33'hFFFF_FFFF ? 32'd1 : 32'd0;
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) r[127 - 32*i -: 32] = lane(a, i) + lane(b, i);
    return r;
  endfunction

  function automatic logic [127:0] ref_nb(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) r[127 - 32*i -: 32] = (lane(a, i) < lane(b, i)) ? 32'd0 : 32'd1;
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic iss, input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    issue_i = iss; instr_i = ins; src_a_i = a; src_b_i = b;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic do_op(input logic [10:0] xo, input logic [127:0] a, input logic [127:0] b,
                       output logic [127:0] r);
    run(1'b1, word(6'd4, 5'd7, 5'd1, 5'd2, xo), a, b);
    r = result_o;
  endtask

  task automatic t_reset;
    check("R9 result", result_o, '0);
    check("R9 flags", {wr_en_o, illegal_o, wr_idx_o}, '0);
  endtask

  task automatic t_carry;
    logic [127:0] a, b, r;
    a = {32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFE};
    b = {32'h0000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001};
    do_op(K_CARRY, a, b, r);
    check("R2 boundary carry", r, ref_carry(a, b));
    check("R2 expected pattern", r, {32'd1, 32'd0, 32'd1, 32'd0});
    check("R10 write strobe", {wr_en_o, illegal_o}, 2'b10);
    a = {4{32'hDEAD_BEEF}}; b = {4{32'hFFFF_0000}};
    do_op(K_CARRY, a, b, r);
    check("R5 flag lanes", r, ref_carry(a, b));
  endtask

  task automatic t_sum;
    logic [127:0] a, b, r;
    a = {32'hFFFF_FFFF, 32'h1234_5678, 32'h0, 32'h8000_0000};
    b = {32'h0000_0002, 32'h1111_1111, 32'h0, 32'h8000_0000};
    do_op(K_SUM, a, b, r);
    check("R3 wrapped sum", r, ref_sum(a, b));
    check("R6 no inter-lane carry", r, {32'h1, 32'h2345_6789, 32'h0, 32'h0});
  endtask

  task automatic t_nb;
    logic [127:0] a, b, r;
    a = {32'h5, 32'h4, 32'h0, 32'hFFFF_FFFF};
    b = {32'h5, 32'h5, 32'h0, 32'hFFFF_FFFE};
    do_op(K_NB, a, b, r);
    check("R4 no-borrow", r, ref_nb(a, b));
    check("R4 equal gives one", r, {32'd1, 32'd0, 32'd1, 32'd1});
  endtask

  task automatic t_order;
    logic [127:0] r;
    do_op(K_CARRY, {32'hFFFF_FFFF, 96'h0}, {32'h1, 96'h0}, r);
    check("R6 lane0 at top", r, {32'd1, 96'h0});
  endtask

  task automatic t_fields;
    run(1'b1, word(6'd4, 5'd19, 5'd19, 5'd3, K_SUM), {4{32'h1}}, {4{32'h2}});
    check("R1 dest index", {123'h0, wr_idx_o}, 128'd19);
    check("R1 aliased dest result", result_o, {4{32'h3}});
    run(1'b1, word(6'd4, 5'd31, 5'd9, 5'd30, K_SUM), {4{32'h1}}, {4{32'h2}});
    check("R1 source fields ignored", result_o, {4{32'h3}});
    check("R1 dest 31", {123'h0, wr_idx_o}, 128'd31);
  endtask

  task automatic t_illegal;
    logic [127:0] keep;
    keep = result_o;
    run(1'b1, word(6'd4, 5'd2, 5'd0, 5'd0, 11'd385), '1, '1);
    check("R7 bad xo flags", {wr_en_o, illegal_o}, 2'b01);
    check("R7 bad xo result kept", result_o, keep);
    run(1'b1, word(6'd5, 5'd2, 5'd0, 5'd0, K_CARRY), '1, '1);
    check("R7 bad primary flags", {wr_en_o, illegal_o}, 2'b01);
    check("R7 bad primary result kept", result_o, keep);
  endtask

  task automatic t_idle;
    logic [127:0] keep;
    keep = result_o;
    run(1'b0, word(6'd4, 5'd1, 5'd0, 5'd0, K_SUM), '1, '1);
    check("R8 idle flags", {wr_en_o, illegal_o}, 2'b00);
    check("R8 idle result kept", result_o, keep);
  endtask

  task automatic t_chain(input logic [127:0] a, input logic [127:0] b, input string tag);
    logic [127:0] x, y, c, s;
    x = a; y = b;
    for (int k = 0; k < 5; k++) begin
      do_op(K_CARRY, x, y, c);
      do_op(K_SUM, x, y, s);
      x = s;
      y = c << 32;
      if (y == '0) break;
    end
    check(tag, x, a + b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_carry();
    t_sum();
    t_nb();
    t_order();
    t_fields();
    t_illegal();
    t_idle();
    t_chain('1, 128'd1, "R2 R3 chain all-ones plus one");
    t_chain({32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF},
            {32'h1, 32'h0000_0001, 32'h8000_0000, 32'h0000_0002}, "R2 R3 chain mixed");
    t_chain({4{32'h1234_5678}}, {4{32'h0FED_CBA9}}, "R2 R3 chain no carry");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule